// File: doc/BRIEF.md
# Paged Host Register Interface

This block is the host-side register front end of a network controller. It sits on a 16-bit slave bus with word addressing. The block decodes each access into one of two regions. The global region holds four words that answer at the same address whatever page is selected: an identifier/trace word, the page-select word and two option words. The paged region is a window of words whose contents depend on a page number that the host writes. The registers behind the window belong to other parts of the controller, so here they are plain read/write storage, one bank per page.

The option words drive the controller core. The low option word is never stored directly. Each write carries a bit mask and, for each byte lane, a flag that chooses between setting and clearing the masked bits. Bit 1 of the low option word is the core's reset. The core is held in reset while that bit is 0, and a one-cycle release strobe marks its rise. The high option word holds three command bits: transmit, advance to the next received packet, and non-volatile load. The host sets a command bit, the core gets a one-cycle start pulse, and the bit stays set, readable as busy, until the core returns the matching done signal.

Reads are combinational from the word address and have no side effects. Writes take effect at the clock edge on which `host_wr` is high. Word address n corresponds to byte offset 2n.

Top module: `paged_host_regs`

## Requirements
- R1: After reset the page number is 0, both option words and the trace word are 0, `core_rst_n` is 0, and no release or command pulse is active.
- R2: Reading word 0 returns the HW_ID parameter. Writing word 0 loads the trace word, which appears on `trace_q`, and does not change what word 0 reads.
- R3: Reading word 1 returns {CHIP_ID[11:0], 1'b0, page[2:0]}. Writing word 1 loads the page number from data bits 2:0 and ignores all other data bits.
- R4: Words 0 to 3 read and write the same registers on every page.
- R5: Words 4 to 4+PAGE_WORDS-1 (4..11 by default) reach a separate storage word for each (page, word) pair. A write on one page does not change the same word on any other page.
- R6: Word addresses above the paged window (12..31 by default) read as 0, and writes to them change nothing.
- R7: A write to word 2 (low option) uses data bits 15:9 as the upper mask and bits 7:1 as the lower mask. Data bit 8 = 1 sets the masked upper bits and 0 clears them. Data bit 0 does the same for the lower bits. Unmasked bits keep their value. Option bits 8 and 0 always read 0.
- R8: `core_rst_n` equals low option bit 1. `core_release` is high for exactly the one cycle after that bit goes from 0 to 1.
- R9: A write to word 3 (high option) stores every data bit except bits 1, 2 and 6 directly.
- R10: High option bits 1 (transmit), 2 (advance) and 6 (load) are command bits. Writing 1 to a clear command bit sets it and raises its pulse output (`tx_pulse`, `adv_pulse`, `ee_pulse`) for the single following cycle. Writing 0, or writing 1 while the bit is set, has no effect and gives no pulse. A set bit stays set until its done input (`tx_done`, `adv_done`, `ee_done`) is high at a clock edge, and then it clears. A done input while the bit is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_waddr | input | WA_W | Word address of the access |
| host_wr | input | 1 | Write strobe, one word per cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from address |
| opt_lo | output | 16 | Low option word toward the core |
| opt_hi | output | 16 | High option word toward the core |
| trace_q | output | 16 | Trace word last written at word 0 |
| core_rst_n | output | 1 | Core reset, active low |
| core_release | output | 1 | One-cycle strobe when the core leaves reset |
| tx_pulse | output | 1 | Transmit command start pulse |
| adv_pulse | output | 1 | Advance-receive command start pulse |
| ee_pulse | output | 1 | Non-volatile load start pulse |
| tx_done | input | 1 | Transmit command finished |
| adv_done | input | 1 | Advance command finished |
| ee_done | input | 1 | Load finished |

## Verification
The hardest cases to reach are those where a command bit meets an event out of turn: a second start write while the bit is still busy, a done signal while the bit is idle, and a done that arrives after unrelated writes to the same word. The bench reaches them by driving done inputs directly, with no core model. It first fills the plain bits of the high option word and then sets individual command bits, so each pulse and each busy flag can be checked separately. Page isolation is covered by writing a distinct value into every word of every page before reading any of them back, so a page decode that aliases shows up as a wrong value.

// File: rtl/paged_host_regs.sv
module paged_host_regs #(
  parameter int          WA_W       = 5,
  parameter int          PAGE_WORDS = 8,
  parameter logic [15:0] HW_ID      = 16'hA5C3,
  parameter logic [11:0] CHIP_ID    = 12'h6E1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] host_waddr,
  input  logic            host_wr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic [15:0]     opt_lo,
  output logic [15:0]     opt_hi,
  output logic [15:0]     trace_q,
  output logic            core_rst_n,
  output logic            core_release,
  output logic            tx_pulse,
  output logic            adv_pulse,
  output logic            ee_pulse,
  input  logic            tx_done,
  input  logic            adv_done,
  input  logic            ee_done
);
  localparam int PAGES       = 8;
  localparam int PG_W        = 3;
  localparam int PW_W        = $clog2(PAGE_WORDS);
  localparam int FIRST_PAGED = 4;
  localparam int LAST_PAGED  = FIRST_PAGED + PAGE_WORDS - 1;
  localparam logic [15:0] CMD_MASK = 16'h0046;
  localparam logic [15:0] UP_MASK  = 16'hFE00;
  localparam logic [15:0] LO_MASK  = 16'h00FE;

  logic [PG_W-1:0]      page_q;
  logic [15:0]          pmem [PAGES*PAGE_WORDS];
  logic                 rst_prev;
  logic [2:0]           pulse_q;
  logic [15:0]          lo_next, hi_next, cmd_set, done_vec;
  logic [PG_W+PW_W-1:0] pidx;
  logic                 in_window;

  assign in_window = (int'(host_waddr) >= FIRST_PAGED) && (int'(host_waddr) <= LAST_PAGED);
  assign pidx      = {page_q, PW_W'(host_waddr - WA_W'(FIRST_PAGED))};

  always_comb begin
    if (host_waddr == WA_W'(0))      host_rdata = HW_ID;
    else if (host_waddr == WA_W'(1)) host_rdata = {CHIP_ID, 1'b0, page_q};
    else if (host_waddr == WA_W'(2)) host_rdata = opt_lo;
    else if (host_waddr == WA_W'(3)) host_rdata = opt_hi;
    else if (in_window)              host_rdata = pmem[pidx];
    else                             host_rdata = 16'h0000;
  end

  always_comb begin
    lo_next = host_wdata[8] ? (opt_lo | (host_wdata & UP_MASK))
                            : (opt_lo & ~(host_wdata & UP_MASK));
    lo_next = host_wdata[0] ? (lo_next | (host_wdata & LO_MASK))
                            : (lo_next & ~(host_wdata & LO_MASK));
  end

  assign cmd_set  = (host_wr && host_waddr == WA_W'(3)) ? (host_wdata & CMD_MASK & ~opt_hi) : 16'h0000;
  assign done_vec = {9'b0, ee_done, 3'b0, adv_done, tx_done, 1'b0};

  always_comb begin
    hi_next = (opt_hi & CMD_MASK & ~done_vec) | cmd_set;
    if (host_wr && host_waddr == WA_W'(3))
      hi_next = hi_next | (host_wdata & ~CMD_MASK);
    else
      hi_next = hi_next | (opt_hi & ~CMD_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      opt_lo   <= '0;
      opt_hi   <= '0;
      trace_q  <= '0;
      rst_prev <= 1'b0;
      pulse_q  <= '0;
      for (int i = 0; i < PAGES*PAGE_WORDS; i++) pmem[i] <= '0;
    end else begin
      rst_prev <= opt_lo[1];
      pulse_q  <= {cmd_set[6], cmd_set[2], cmd_set[1]};
      opt_hi   <= hi_next;
      if (host_wr) begin
        if (host_waddr == WA_W'(0)) trace_q <= host_wdata;
        if (host_waddr == WA_W'(1)) page_q  <= host_wdata[PG_W-1:0];
        if (host_waddr == WA_W'(2)) opt_lo  <= lo_next;
        if (in_window)              pmem[pidx] <= host_wdata;
      end
    end
  end

  assign core_rst_n   = opt_lo[1];
  assign core_release = opt_lo[1] & ~rst_prev;
  assign tx_pulse     = pulse_q[0];
  assign adv_pulse    = pulse_q[1];
  assign ee_pulse     = pulse_q[2];
endmodule

module phr_checker #(
  parameter int WA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WA_W-1:0] host_waddr,
  input logic            host_wr,
  input logic [15:0]     opt_lo,
  input logic [15:0]     opt_hi,
  input logic            core_rst_n,
  input logic            core_release,
  input logic            tx_pulse,
  input logic            adv_pulse,
  input logic            tx_done,
  input logic            adv_done
);
  a_r10_tx_single: assert property (@(posedge clk) disable iff (!rst_n) tx_pulse |=> !tx_pulse);
  a_r10_tx_flag:   assert property (@(posedge clk) disable iff (!rst_n) tx_pulse |-> opt_hi[1] && !$past(opt_hi[1]));
  a_r10_tx_hold:   assert property (@(posedge clk) disable iff (!rst_n) opt_hi[1] && !tx_done |=> opt_hi[1]);
  a_r10_tx_clear:  assert property (@(posedge clk) disable iff (!rst_n) opt_hi[1] && tx_done |=> !opt_hi[1]);
  a_r10_adv_hold:  assert property (@(posedge clk) disable iff (!rst_n) opt_hi[2] && !adv_done |=> opt_hi[2]);
  a_r10_adv_single: assert property (@(posedge clk) disable iff (!rst_n) adv_pulse |=> !adv_pulse);
  a_r8_release:    assert property (@(posedge clk) disable iff (!rst_n) core_release |-> core_rst_n && !$past(core_rst_n));
  a_r7_lane_flags: assert property (@(posedge clk) disable iff (!rst_n) !opt_lo[0] && !opt_lo[8]);
  a_r7_lo_stable:  assert property (@(posedge clk) disable iff (!rst_n)
                     !(host_wr && host_waddr == WA_W'(2)) |=> $stable(opt_lo));
endmodule

bind paged_host_regs phr_checker #(.WA_W(WA_W)) u_chk (.*);

// File: tb/sim_paged_host_regs.sv
module sim_paged_host_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] HWID = 16'hA5C3;
  localparam logic [11:0] CID  = 12'h6E1;

  logic clk = 0, rst_n = 0, host_wr = 0;
  logic [4:0]  host_waddr = 0;
  logic [15:0] host_wdata = 0, host_rdata, opt_lo, opt_hi, trace_q;
  logic core_rst_n, core_release, tx_pulse, adv_pulse, ee_pulse;
  logic tx_done = 0, adv_done = 0, ee_done = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  paged_host_regs #(.WA_W(5), .PAGE_WORDS(8), .HW_ID(HWID), .CHIP_ID(CID)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); host_waddr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); host_waddr = a; #1 d = host_rdata;
  endtask

  function automatic logic [15:0] pv(int p, int w);
    return 16'(p * 16'h1111) ^ 16'(w * 16'h0203) ^ 16'h5A00;
  endfunction

  function automatic logic [15:0] lo_model(logic [15:0] cur, logic [15:0] w);
    logic [15:0] r;
    r = w[8] ? (cur | (w & 16'hFE00)) : (cur & ~(w & 16'hFE00));
    r = w[0] ? (r | (w & 16'h00FE)) : (r & ~(w & 16'h00FE));
    return r;
  endfunction

  initial begin
    logic [15:0] d, exp_lo;
    logic [15:0] pats [8] = '{16'h0003, 16'hFF01, 16'hAB00, 16'h0004,
                              16'h0002, 16'h0103, 16'h5500, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 core_rst_n", {15'b0, core_rst_n}, 16'h0);
    chk("R1 opt_lo", opt_lo, 16'h0);
    chk("R1 opt_hi", opt_hi, 16'h0);
    chk("R1 trace", trace_q, 16'h0);
    chk("R1 pulses", {12'b0, core_release, tx_pulse, adv_pulse, ee_pulse}, 16'h0);
    rd(1, d); chk("R1 page0", d, {CID, 4'h0});

    rd(0, d); chk("R2 hwid", d, HWID);
    wr(0, 16'h1234);
    chk("R2 trace", trace_q, 16'h1234);
    rd(0, d); chk("R2 hwid after write", d, HWID);

    for (int p = 0; p < 8; p++) begin
      wr(1, 16'(p));
      for (int w = 0; w < 8; w++) wr(5'(4 + w), pv(p, w));
    end
    for (int p = 0; p < 8; p++) begin
      wr(1, 16'hFFF8 | 16'(p));
      rd(1, d); chk("R3 page select", d, {CID, 1'b0, 3'(p)});
      rd(0, d); chk("R4 global hwid per page", d, HWID);
      rd(2, d); chk("R4 global opt per page", d, 16'h0);
      for (int w = 0; w < 8; w++) begin
        rd(5'(4 + w), d); chk("R5 paged storage", d, pv(p, w));
      end
    end

    wr(1, 16'h0003);
    for (int a = 12; a < 32; a++) begin
      wr(5'(a), 16'hFFFF);
      rd(5'(a), d); chk("R6 unimplemented reads 0", d, 16'h0);
    end
    for (int w = 0; w < 8; w++) begin
      rd(5'(4 + w), d); chk("R6 window untouched", d, pv(3, w));
    end

    exp_lo = 16'h0;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] nx;
      nx = lo_model(exp_lo, pats[i]);
      wr(2, pats[i]);
      chk("R7 opt_lo port", opt_lo, nx);
      chk("R8 core_rst_n", {15'b0, core_rst_n}, {15'b0, nx[1]});
      chk("R8 release strobe", {15'b0, core_release}, {15'b0, nx[1] & ~exp_lo[1]});
      exp_lo = nx;
      @(negedge clk);
      chk("R8 release ends", {15'b0, core_release}, 16'h0);
      rd(2, d); chk("R7 opt_lo read", d, exp_lo);
    end

    wr(3, 16'hFFB9);
    chk("R9 plain bits", opt_hi, 16'hFFB9);
    chk("R10 no pulse on plain", {13'b0, tx_pulse, adv_pulse, ee_pulse}, 16'h0);
    wr(3, 16'h0002);
    chk("R10 tx pulse", {13'b0, tx_pulse, adv_pulse, ee_pulse}, 16'h0004);
    chk("R9 plain cleared, R10 tx busy", opt_hi, 16'h0002);
    @(negedge clk);
    chk("R10 tx pulse one cycle", {15'b0, tx_pulse}, 16'h0);
    wr(3, 16'h0000);
    chk("R10 write 0 no effect", opt_hi, 16'h0002);
    wr(3, 16'h0002);
    chk("R10 rewrite while busy no pulse", {15'b0, tx_pulse}, 16'h0);
    @(negedge clk); adv_done = 1; @(negedge clk); adv_done = 0;
    chk("R10 done while idle ignored", opt_hi, 16'h0002);
    repeat (3) @(negedge clk);
    rd(3, d); chk("R10 busy held", d, 16'h0002);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    chk("R10 tx cleared by done", opt_hi, 16'h0000);
    wr(3, 16'h0044);
    chk("R10 adv+load pulses", {13'b0, tx_pulse, adv_pulse, ee_pulse}, 16'h0003);
    chk("R10 adv+load busy", opt_hi, 16'h0044);
    @(negedge clk); ee_done = 1; @(negedge clk); ee_done = 0;
    chk("R10 load cleared", opt_hi, 16'h0004);
    @(negedge clk); adv_done = 1; @(negedge clk); adv_done = 0;
    rd(3, d); chk("R10 adv cleared", d, 16'h0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule